// File: doc/BRIEF.md
# MII Receive Path with Destination Filter

This block sits behind a 4-bit media-independent receive interface. It takes one nibble per clock while the data-valid strobe is high and skips the preamble. Frame data starts after the start delimiter. The block joins nibble pairs into bytes and streams the bytes into a frame buffer through a plain write port, starting at address 0. The first six bytes (the destination address) are always written. Once they have arrived, the destination is sorted into one of three accepted classes: the local station address, the all-ones broadcast address, or an IPv4-mapped group address. An address in no accepted class stops further writes, and the frame then yields no status.

At the end of every accepted frame, a single-cycle status pulse reports five things: the address class, the byte count, the two-byte type field, the result of the CRC-32 check, and a misalignment flag. A single "good" bit combines the CRC result, the length window and the alignment. A consumer keeps a frame only when that bit is set.

The receive side cannot be stalled, because the line sets the pace. For that reason, neither the write port nor the status pulse has a ready input. The buffer must accept one byte every two clocks, and the status must be taken in the cycle it appears.

Top module: `mii_rx_filter`

## Requirements
- R1: Each byte is built from two nibbles: the first nibble received is bits 3:0 and the second is bits 7:4. Bytes are written to ascending addresses in arrival order.
- R2: Nibbles before the delimiter are not written. Data starts after a 0xD nibble that directly follows a 0x5 nibble (the 0xD5 byte). Byte 0 is the first destination octet. A burst without that delimiter produces no write and no status.
- R3: A destination equal to `local_addr` is accepted with `stat_class` = 1 (unicast). On `local_addr`, bits 47:40 are the first octet on the wire.
- R4: The destination FF:FF:FF:FF:FF:FF is always accepted with `stat_class` = 2 (broadcast).
- R5: A destination whose first three octets are 01:00:5E and whose next bit (the top bit of the fourth octet) is 0 is accepted with `stat_class` = 3. Any other address with bit 0 of the first octet set is rejected.
- R6: A rejected destination causes writes for bytes 0 to 5 only, and no status pulse.
- R7: `stat_type` equals byte 12 shifted left by 8, ORed with byte 13.
- R8: `stat_crc_ok` is 1 exactly when the reflected CRC-32 (polynomial 0xEDB88320, preset all ones) run over every byte, including the final four FCS bytes, leaves the residue 0xDEBB20E3.
- R9: `stat_len` counts bytes from the destination through the FCS, and saturates at 1519. No byte at an index of 1518 or more is written. The length is in range only for counts of 64 to 1518.
- R10: If the valid strobe falls with a lone nibble pending, `stat_misaligned` is 1 and the lone nibble is neither written nor counted.
- R11: Exactly one `stat_valid` pulse of one cycle follows each accepted frame. `stat_good` is 1 only when the CRC passes, the length is in range and the frame is aligned.
- R12: During and right after reset, `mem_wr_en` and `stat_valid` are 0. A frame cut by reset yields no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mii_rxd | input | 4 | Receive nibble |
| mii_rx_dv | input | 1 | Receive data valid |
| local_addr | input | 48 | Station address, first octet in bits 47:40 |
| mem_wr_en | output | 1 | Frame buffer write strobe |
| mem_wr_addr | output | 11 | Byte index within the frame |
| mem_wr_data | output | 8 | Byte to write |
| stat_valid | output | 1 | One-cycle end-of-frame status strobe |
| stat_good | output | 1 | Frame fit to keep |
| stat_crc_ok | output | 1 | CRC residue matched |
| stat_misaligned | output | 1 | Odd nibble count |
| stat_class | output | 2 | 1 unicast, 2 broadcast, 3 multicast |
| stat_len | output | 11 | Byte count, saturating at 1519 |
| stat_type | output | 16 | Type field |

## Verification
The bench sends the 01:00:5E prefix with the bit after it set, and a group address outside that prefix. A filter that tests only the prefix, or only the group bit, would accept these and raise a status. It also sends frames of 63, 64, 1518 and 1519 bytes. An off-by-one window would mark the wrong one good, and a missing cap would write index 1518. A trailing lone nibble and a corrupted FCS must each clear `stat_good` while the CRC verdict stays correct. A preamble with no delimiter must write nothing, which catches a receiver that starts on any nibble.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_UCAST = 2'd1,
    CLS_BCAST = 2'd2,
    CLS_MCAST = 2'd3
  } dst_class_e;

  localparam logic [31:0] CRC_POLY_R  = 32'hEDB88320;
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;

  // Advance a reflected CRC-32 register by one byte, LSB first.
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_R;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/mii_rx_nibbler.sv
module mii_rx_nibbler #(
  parameter int NIB_W = 4,
  parameter logic [NIB_W-1:0] PRE_NIB = 4'h5,
  parameter logic [NIB_W-1:0] SFD_NIB = 4'hD,
  localparam int BYTE_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIB_W-1:0]  rxd,
  input  logic              rx_dv,
  output logic              sof,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_out,
  output logic              eof,
  output logic              eof_odd
);
  logic             in_data;
  logic             half;
  logic             prev_pre;
  logic [NIB_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_data  <= 1'b0;
      half     <= 1'b0;
      prev_pre <= 1'b0;
      lo_q     <= '0;
      sof      <= 1'b0;
      byte_vld <= 1'b0;
      byte_out <= '0;
      eof      <= 1'b0;
      eof_odd  <= 1'b0;
    end else begin
      sof      <= 1'b0;
      byte_vld <= 1'b0;
      eof      <= 1'b0;
      if (!rx_dv) begin
        if (in_data) begin
          eof     <= 1'b1;
          eof_odd <= half;
        end
        in_data  <= 1'b0;
        half     <= 1'b0;
        prev_pre <= 1'b0;
      end else if (!in_data) begin
        if (rxd == SFD_NIB && prev_pre) begin
          in_data <= 1'b1;
          half    <= 1'b0;
          sof     <= 1'b1;
        end
        prev_pre <= (rxd == PRE_NIB);
      end else if (!half) begin
        lo_q <= rxd;
        half <= 1'b1;
      end else begin
        byte_out <= {rxd, lo_q};
        byte_vld <= 1'b1;
        half     <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mii_rx_addr_match.sv
module mii_rx_addr_match
  import mii_rx_pkg::*;
#(
  parameter int MAC_W = 48,
  parameter int OUI_W = 24,
  parameter logic [OUI_W-1:0] MCAST_OUI = 24'h01005E,
  localparam int GRP_BIT  = MAC_W - 8,
  localparam int GAP_BIT  = MAC_W - OUI_W - 1
) (
  input  logic [MAC_W-1:0] dst,
  input  logic [MAC_W-1:0] local_addr,
  output dst_class_e       cls
);
  logic is_bcast, is_group, ip_map;

  assign is_bcast = &dst;
  assign is_group = dst[GRP_BIT];
  assign ip_map   = (dst[MAC_W-1 -: OUI_W] == MCAST_OUI) && !dst[GAP_BIT];

  always_comb begin
    if (is_bcast)                 cls = CLS_BCAST;
    else if (dst == local_addr)   cls = CLS_UCAST;
    else if (is_group && ip_map)  cls = CLS_MCAST;
    else                          cls = CLS_NONE;
  end
endmodule

// File: rtl/mii_rx_fcs_check.sv
module mii_rx_fcs_check
  import mii_rx_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              crc_ok
);
  logic [31:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) crc_q <= '1;
    else if (byte_vld) crc_q <= crc_step(crc_q, byte_in);
  end

  assign crc_ok = (crc_q == CRC_RESIDUE);
endmodule

// File: rtl/mii_rx_filter.sv
module mii_rx_filter
  import mii_rx_pkg::*;
#(
  parameter int MAC_W     = 48,
  parameter int NIB_W     = 4,
  parameter int TYPE_W    = 16,
  parameter int MIN_FRAME = 64,
  parameter int MAX_FRAME = 1518,
  localparam int BYTE_W = 2 * NIB_W,
  localparam int ADDR_W = $clog2(MAX_FRAME),
  localparam int LEN_W  = $clog2(MAX_FRAME + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIB_W-1:0]  mii_rxd,
  input  logic              mii_rx_dv,
  input  logic [MAC_W-1:0]  local_addr,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [BYTE_W-1:0] mem_wr_data,
  output logic              stat_valid,
  output logic              stat_good,
  output logic              stat_crc_ok,
  output logic              stat_misaligned,
  output logic [1:0]        stat_class,
  output logic [LEN_W-1:0]  stat_len,
  output logic [TYPE_W-1:0] stat_type
);
  localparam int DST_BYTES = MAC_W / BYTE_W;
  localparam logic [LEN_W-1:0] DST_END  = LEN_W'(DST_BYTES);
  localparam logic [LEN_W-1:0] TYPE_HI  = LEN_W'(2 * DST_BYTES);
  localparam logic [LEN_W-1:0] TYPE_LO  = LEN_W'(2 * DST_BYTES + 1);
  localparam logic [LEN_W-1:0] LEN_MIN  = LEN_W'(MIN_FRAME);
  localparam logic [LEN_W-1:0] LEN_MAX  = LEN_W'(MAX_FRAME);
  localparam logic [LEN_W-1:0] LEN_SAT  = LEN_W'(MAX_FRAME + 1);

  logic              sof, byte_vld, eof, eof_odd;
  logic [BYTE_W-1:0] byte_d;
  logic              crc_ok;
  dst_class_e        cls;

  logic [LEN_W-1:0]  cnt_q;
  logic [MAC_W-1:0]  dst_q;
  logic [TYPE_W-1:0] type_q;
  logic              pass, wr_now, in_window;

  mii_rx_nibbler #(.NIB_W(NIB_W)) u_nib (
    .clk(clk), .rst_n(rst_n), .rxd(mii_rxd), .rx_dv(mii_rx_dv),
    .sof(sof), .byte_vld(byte_vld), .byte_out(byte_d),
    .eof(eof), .eof_odd(eof_odd)
  );

  mii_rx_addr_match #(.MAC_W(MAC_W)) u_match (
    .dst(dst_q), .local_addr(local_addr), .cls(cls)
  );

  mii_rx_fcs_check #(.BYTE_W(BYTE_W)) u_fcs (
    .clk(clk), .rst_n(rst_n), .clr(sof), .byte_vld(byte_vld),
    .byte_in(byte_d), .crc_ok(crc_ok)
  );

  // Destination bytes pass while still arriving; afterwards only a classified frame does.
  assign pass      = (cnt_q < DST_END) || (cls != CLS_NONE);
  assign wr_now    = byte_vld && pass && (cnt_q < LEN_MAX);
  assign in_window = (cnt_q >= LEN_MIN) && (cnt_q <= LEN_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      dst_q  <= '0;
      type_q <= '0;
    end else if (sof) begin
      cnt_q  <= '0;
      type_q <= '0;
    end else if (byte_vld) begin
      if (cnt_q < DST_END) dst_q <= {dst_q[MAC_W-BYTE_W-1:0], byte_d};
      if (cnt_q == TYPE_HI) type_q[TYPE_W-1 -: BYTE_W] <= byte_d;
      if (cnt_q == TYPE_LO) type_q[BYTE_W-1:0] <= byte_d;
      if (cnt_q != LEN_SAT) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_wr_en   <= 1'b0;
      mem_wr_addr <= '0;
      mem_wr_data <= '0;
    end else begin
      mem_wr_en <= wr_now;
      if (wr_now) begin
        mem_wr_addr <= cnt_q[ADDR_W-1:0];
        mem_wr_data <= byte_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_valid      <= 1'b0;
      stat_good       <= 1'b0;
      stat_crc_ok     <= 1'b0;
      stat_misaligned <= 1'b0;
      stat_class      <= 2'd0;
      stat_len        <= '0;
      stat_type       <= '0;
    end else begin
      stat_valid <= 1'b0;
      if (eof && (cnt_q >= DST_END) && (cls != CLS_NONE)) begin
        stat_valid      <= 1'b1;
        stat_crc_ok     <= crc_ok;
        stat_misaligned <= eof_odd;
        stat_good       <= crc_ok && in_window && !eof_odd;
        stat_class      <= cls;
        stat_len        <= cnt_q;
        stat_type       <= type_q;
      end
    end
  end
endmodule

// File: rtl/mii_rx_filter_chk.sv
module mii_rx_filter_chk #(
  parameter int MIN_FRAME = 64,
  parameter int MAX_FRAME = 1518,
  parameter int ADDR_W = 11,
  parameter int LEN_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mii_rx_dv,
  input logic              mem_wr_en,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic              stat_valid,
  input logic              stat_good,
  input logic              stat_crc_ok,
  input logic              stat_misaligned,
  input logic [1:0]        stat_class,
  input logic [LEN_W-1:0]  stat_len
);
  // R6: a status pulse only ever carries an accepted class
  a_r6_status_has_class: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> stat_class != 2'd0);

  // R9: no write at or beyond the maximum frame size
  a_r9_wr_addr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> int'(mem_wr_addr) < MAX_FRAME);

  // R11: good requires CRC, alignment and the length window
  a_r11_good_needs_all: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && stat_good) |-> (stat_crc_ok && !stat_misaligned &&
      int'(stat_len) >= MIN_FRAME && int'(stat_len) <= MAX_FRAME));

  // R10: a misaligned frame is never good
  a_r10_misaligned_bad: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && stat_misaligned) |-> !stat_good);

  // R11: the status strobe lasts one cycle
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |=> !stat_valid);

  // R12: writes cease once the line has been idle for three samples
  a_r12_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!mii_rx_dv && !$past(mii_rx_dv) && !$past(mii_rx_dv, 2)) |-> !mem_wr_en);
endmodule

bind mii_rx_filter mii_rx_filter_chk #(
  .MIN_FRAME(MIN_FRAME), .MAX_FRAME(MAX_FRAME), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mii_rx_dv(mii_rx_dv), .mem_wr_en(mem_wr_en),
  .mem_wr_addr(mem_wr_addr), .stat_valid(stat_valid), .stat_good(stat_good),
  .stat_crc_ok(stat_crc_ok), .stat_misaligned(stat_misaligned),
  .stat_class(stat_class), .stat_len(stat_len)
);

// File: tb/test_mii_rx_filter.sv
module test_mii_rx_filter;
  localparam int CLK_PERIOD = 10;
  localparam logic [47:0] MY_ADDR = 48'h02ABCDEF0123;

  logic        clk, rst_n;
  logic [3:0]  mii_rxd;
  logic        mii_rx_dv;
  logic        mem_wr_en;
  logic [10:0] mem_wr_addr;
  logic [7:0]  mem_wr_data;
  logic        stat_valid, stat_good, stat_crc_ok, stat_misaligned;
  logic [1:0]  stat_class;
  logic [10:0] stat_len;
  logic [15:0] stat_type;

  mii_rx_filter i_mii_rx_filter (
    .clk(clk), .rst_n(rst_n), .mii_rxd(mii_rxd), .mii_rx_dv(mii_rx_dv),
    .local_addr(MY_ADDR), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .stat_valid(stat_valid), .stat_good(stat_good),
    .stat_crc_ok(stat_crc_ok), .stat_misaligned(stat_misaligned),
    .stat_class(stat_class), .stat_len(stat_len), .stat_type(stat_type)
  );

  typedef struct packed {
    logic [47:0] dst;
    logic [15:0] etype;
    logic [10:0] plen;
    logic        bad_fcs;
    logic        odd;
    logic [1:0]  exp_cls;
    logic        exp_good;
    logic        exp_crc;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{48'h02ABCDEF0123, 16'h0800, 11'd46,   1'b0, 1'b0, 2'd1, 1'b1, 1'b1},
    '{48'hFFFFFFFFFFFF, 16'h0806, 11'd50,   1'b0, 1'b0, 2'd2, 1'b1, 1'b1},
    '{48'h01005E0000FB, 16'h0800, 11'd60,   1'b0, 1'b0, 2'd3, 1'b1, 1'b1},
    '{48'h01005E800001, 16'h0800, 11'd60,   1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    '{48'h030000000001, 16'h0800, 11'd60,   1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    '{48'h02ABCDEF0124, 16'h0800, 11'd60,   1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    '{48'h02ABCDEF0123, 16'h0800, 11'd46,   1'b1, 1'b0, 2'd1, 1'b0, 1'b0},
    '{48'h02ABCDEF0123, 16'h0800, 11'd45,   1'b0, 1'b0, 2'd1, 1'b0, 1'b1},
    '{48'h02ABCDEF0123, 16'h86DD, 11'd70,   1'b0, 1'b1, 2'd1, 1'b0, 1'b1},
    '{48'h02ABCDEF0123, 16'h0800, 11'd1500, 1'b0, 1'b0, 2'd1, 1'b1, 1'b1},
    '{48'hFFFFFFFFFFFF, 16'h0800, 11'd1501, 1'b0, 1'b0, 2'd2, 1'b0, 1'b1},
    '{48'h01005E7FFFFF, 16'h1234, 11'd46,   1'b0, 1'b0, 2'd3, 1'b1, 1'b1}
  };

  int n_chk = 0, n_err = 0;
  logic [7:0] frm [0:2047];
  logic [7:0] cap [0:2047];
  int flen;
  int wr_cnt, st_cnt;
  logic        s_good, s_crc, s_mis;
  logic [1:0]  s_cls;
  logic [10:0] s_len;
  logic [15:0] s_type;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (mem_wr_en) begin
      cap[mem_wr_addr] = mem_wr_data;
      wr_cnt++;
    end
    if (stat_valid) begin
      st_cnt++;
      s_good = stat_good; s_crc = stat_crc_ok; s_mis = stat_misaligned;
      s_cls = stat_class; s_len = stat_len; s_type = stat_type;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] fcs_of(input int len);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < len; i++) begin
      c = c ^ {24'd0, frm[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic build(input vec_t v);
    logic [31:0] f;
    for (int i = 0; i < 6; i++) frm[i] = v.dst[47 - 8*i -: 8];
    for (int i = 0; i < 6; i++) frm[6+i] = 8'h10 + 8'(i);
    frm[12] = v.etype[15:8];
    frm[13] = v.etype[7:0];
    for (int i = 0; i < int'(v.plen); i++) frm[14+i] = 8'(i*7 + 3);
    flen = 14 + int'(v.plen);
    f = fcs_of(flen);
    for (int i = 0; i < 4; i++) frm[flen+i] = f[8*i +: 8];
    flen = flen + 4;
    if (v.bad_fcs) frm[flen-1] = frm[flen-1] ^ 8'h01;
  endtask

  task automatic nib(input logic [3:0] n);
    @(negedge clk);
    mii_rxd = n;
    mii_rx_dv = 1'b1;
  endtask

  task automatic idle(input int cycles);
    @(negedge clk);
    mii_rx_dv = 1'b0;
    mii_rxd = 4'h0;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic send(input int len, input bit odd);
    for (int i = 0; i < 15; i++) nib(4'h5);
    nib(4'hD);
    for (int i = 0; i < len; i++) begin
      nib(frm[i][3:0]);
      nib(frm[i][7:4]);
    end
    if (odd) nib(4'h6);
    idle(24);
  endtask

  initial begin
    rst_n = 1'b0; mii_rx_dv = 1'b0; mii_rxd = 4'h0;
    wr_cnt = 0; st_cnt = 0;
    repeat (4) @(negedge clk);
    // R12: outputs quiet in reset
    check(mem_wr_en == 1'b0, "R12", "wr_en in reset", mem_wr_en, 0);
    check(stat_valid == 1'b0, "R12", "stat_valid in reset", stat_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(mem_wr_en == 1'b0 && stat_valid == 1'b0, "R12", "quiet after reset",
          {mem_wr_en, stat_valid}, 0);

    for (int k = 0; k < NVEC; k++) begin
      vec_t v;
      int tot, exp_wr, bad;
      string creq;
      v = VECS[k];
      build(v);
      tot = flen;
      wr_cnt = 0; st_cnt = 0;
      send(tot, v.odd);
      creq = (v.exp_cls == 2'd1) ? "R3" : (v.exp_cls == 2'd2) ? "R4" : "R5";
      if (v.exp_cls == 2'd0) begin
        check(st_cnt == 0, "R6", "status count on reject", st_cnt, 0);
        check(wr_cnt == 6, "R6", "writes on reject", wr_cnt, 6);
        exp_wr = 6;
        if (v.dst[40]) check(st_cnt == 0, "R5", "group address refused", st_cnt, 0);
      end else begin
        exp_wr = (tot > 1518) ? 1518 : tot;
        check(st_cnt == 1, "R11", "status count", st_cnt, 1);
        check(s_cls == v.exp_cls, creq, "class", s_cls, v.exp_cls);
        check(s_good == v.exp_good, "R11", "good", s_good, v.exp_good);
        check(s_crc == v.exp_crc, "R8", "crc_ok", s_crc, v.exp_crc);
        check(int'(s_len) == ((tot > 1519) ? 1519 : tot), "R9", "length", s_len, tot);
        check(s_type == v.etype, "R7", "type", s_type, v.etype);
        check(s_mis == v.odd, "R10", "misaligned", s_mis, v.odd);
        check(wr_cnt == exp_wr, "R9", "write count", wr_cnt, exp_wr);
      end
      bad = 0;
      for (int i = 0; i < exp_wr; i++) if (cap[i] !== frm[i]) bad++;
      check(bad == 0, "R1", "byte mismatches", bad, 0);
      check(cap[0] == v.dst[47:40], "R2", "first byte is destination", cap[0], v.dst[47:40]);
    end

    // R2: preamble without delimiter
    wr_cnt = 0; st_cnt = 0;
    for (int i = 0; i < 20; i++) nib(4'h5);
    idle(24);
    check(wr_cnt == 0 && st_cnt == 0, "R2", "no delimiter activity", wr_cnt + st_cnt, 0);

    // R12: reset in the middle of a frame
    build(VECS[0]);
    wr_cnt = 0; st_cnt = 0;
    for (int i = 0; i < 15; i++) nib(4'h5);
    nib(4'hD);
    for (int i = 0; i < 20; i++) begin nib(frm[i][3:0]); nib(frm[i][7:4]); end
    rst_n = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(24);
    check(st_cnt == 0, "R12", "status after cut frame", st_cnt, 0);

    // R3: recovery after reset
    wr_cnt = 0; st_cnt = 0;
    send(flen, 1'b0);
    check(st_cnt == 1 && s_good && s_cls == 2'd1, "R3", "frame after reset", st_cnt, 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule